// File: doc/BRIEF.md
# Write precompensation pulse shifter

This block sits between a disk controller and a drive on the write path. Each rising edge on the write-data input is re-emitted as one fixed-width pulse, delayed by a fixed base plus a shift. The shift depends on whether the controller flagged the bit as early, nominal or late, on a 3-bit amount select and on a 2-bit data-rate select. All timing is counted in ticks of the block clock, and one tick is one precompensation unit.

The controller may settle its early and late requests some time after the data edge. For that reason the requests, the amount select and the rate select are all captured a fixed number of ticks after the accepted edge, not at the edge itself. An illegal combination raises a one-tick error flag, and that pulse then leaves with nominal timing. A new edge that arrives while a pulse is still in flight is dropped and reported on a one-tick overrun flag.

Top module: `wpc_shifter`

## Requirements
- R1: While reset is asserted, `wr_out`, `cfg_err` and `overrun` are all low, whatever the inputs do.
- R2: Only a rising edge of `wr_in` starts a pulse. A level or a falling edge does not. Each accepted edge produces exactly one `wr_out` pulse, high for exactly PULSE_TICKS ticks.
- R3: With `rate_sel` = 2'b00, amount codes 0 to 7 select shifts of 0, 3, 4, 5, 6, 7, 9 and 11 ticks.
- R4: With `rate_sel` = 2'b01 or 2'b10, amount codes 0 to 5 select a shift equal to the code. With `rate_sel` = 2'b01, codes 6 and 7 select 6 and 7 ticks.
- R5: Let the accepted edge be the clock edge that first samples `wr_in` high, and count D clock edges from it to the edge after which `wr_out` is high. Then D = BASE_TICKS when only `early_req` is high, D = BASE_TICKS + shift when neither request is high, and D = BASE_TICKS + 2 × shift when only `late_req` is high.
- R6: `early_req`, `late_req`, `amt_sel` and `rate_sel` are used only at clock edge SAMPLE_TICKS after the accepted edge. Their values at any other time have no effect on the pulse.
- R7: Some settings are illegal at the sample point: both requests high, `rate_sel` = 2'b11 (test mode), or `rate_sel` = 2'b10 with an amount code of 6 or 7. For any of these, `cfg_err` is high for exactly the one tick that follows that sample edge. Both requests high gives the nominal shift. An illegal rate or amount gives a shift of 0, so D = BASE_TICKS.
- R8: A rising edge of `wr_in` is ignored if it is sampled at any clock edge from the one after the accepted edge up to and including the edge on which `wr_out` falls. Such an edge raises `overrun` for one tick, does not change the pulse in flight and produces no pulse of its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock. One period is one precompensation unit. |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_in | input | 1 | Write data from the controller. Rising edges are used. |
| early_req | input | 1 | Controller request to send the bit early |
| late_req | input | 1 | Controller request to send the bit late |
| amt_sel | input | 3 | Precompensation amount code |
| rate_sel | input | 2 | Data-rate code. 2'b11 is test mode. |
| wr_out | output | 1 | Delayed write pulse to the drive |
| cfg_err | output | 1 | One-tick flag for an illegal setting at the sample point |
| overrun | output | 1 | One-tick flag for an edge dropped while busy |

## Verification
The bench builds the block with BASE_TICKS = 4, SAMPLE_TICKS = 2 and PULSE_TICKS = 6. With these values the shortest delay (4) and the longest (4 + 22) both fit within a short run of ticks. The sample point also lies strictly between the accepted edge and the earliest possible output, so scrambling the select inputs on every tick except the sample tick shows whether the block reads them anywhere else. The busy window reaches 32 ticks at most, which lets randomly placed second edges land anywhere from the tick after acceptance up to the final high tick of the output.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  localparam int unsigned MAX_SHIFT = 11;
  localparam int unsigned SHIFT_W   = 4;

  localparam logic [1:0] RATE_SLOW = 2'b00;
  localparam logic [1:0] RATE_MID  = 2'b01;
  localparam logic [1:0] RATE_FAST = 2'b10;
  localparam logic [1:0] RATE_TEST = 2'b11;

  typedef enum logic [1:0] {
    DIR_NOMINAL = 2'd0,
    DIR_EARLY   = 2'd1,
    DIR_LATE    = 2'd2
  } dir_e;

  typedef struct packed {
    logic               legal;
    logic [SHIFT_W-1:0] units;
  } shift_t;

  // Shift in ticks for an amount code at a data rate. An illegal combination gives zero.
  function automatic shift_t shift_lookup(input logic [2:0] amt, input logic [1:0] rate);
    shift_t s;
    s.legal = 1'b1;
    s.units = '0;
    unique case (rate)
      RATE_SLOW: begin
        if (amt == 3'd0)       s.units = 4'd0;
        else if (amt <= 3'd5)  s.units = {1'b0, amt} + 4'd2;
        else if (amt == 3'd6)  s.units = 4'd9;
        else                   s.units = 4'd11;
      end
      RATE_MID: s.units = {1'b0, amt};
      RATE_FAST: begin
        if (amt <= 3'd5) s.units = {1'b0, amt};
        else             s.legal = 1'b0;
      end
      default: s.legal = 1'b0;
    endcase
    return s;
  endfunction

  // Direction of the shift. Conflicting or absent requests give nominal timing.
  function automatic dir_e pick_dir(input logic early, input logic late);
    dir_e d;
    unique case ({early, late})
      2'b10:   d = DIR_EARLY;
      2'b01:   d = DIR_LATE;
      default: d = DIR_NOMINAL;
    endcase
    return d;
  endfunction

  // Ticks added on top of the base delay.
  function automatic logic [SHIFT_W:0] extra_ticks(input dir_e d, input logic [SHIFT_W-1:0] u);
    logic [SHIFT_W:0] x;
    unique case (d)
      DIR_EARLY: x = '0;
      DIR_LATE:  x = {u, 1'b0};
      default:   x = {1'b0, u};
    endcase
    return x;
  endfunction

endpackage

// File: rtl/wpc_edge_gate.sv
module wpc_edge_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_in,
  input  logic busy,
  output logic accept,
  output logic overrun
);

  logic wr_q;
  logic rise;

  assign rise   = wr_in && !wr_q;
  assign accept = rise && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      wr_q    <= wr_in;
      overrun <= rise && busy;
    end
  end

endmodule

// File: rtl/wpc_delay_sel.sv
module wpc_delay_sel
  import wpc_pkg::*;
#(
  parameter int unsigned BASE_TICKS   = 4,
  parameter int unsigned SAMPLE_TICKS = 2,
  parameter int unsigned CNT_W        = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic [CNT_W-1:0] cnt,
  input  logic             early_req,
  input  logic             late_req,
  input  logic [2:0]       amt_sel,
  input  logic [1:0]       rate_sel,
  output logic             sample_stb,
  output logic [CNT_W-1:0] tgt,
  output logic             cfg_err
);

  shift_t sh;
  dir_e   dir;
  logic   bad;

  always_comb begin
    sh  = shift_lookup(amt_sel, rate_sel);
    dir = pick_dir(early_req, late_req);
    bad = !sh.legal || (early_req && late_req);
  end

  assign sample_stb = busy && (cnt == CNT_W'(SAMPLE_TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt     <= '0;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= sample_stb && bad;
      if (sample_stb) begin
        tgt <= CNT_W'(BASE_TICKS) + CNT_W'(extra_ticks(dir, sh.units));
      end
    end
  end

endmodule

// File: rtl/wpc_pulse_gen.sv
module wpc_pulse_gen #(
  parameter int unsigned PULSE_TICKS = 6,
  parameter int unsigned CNT_W       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [CNT_W-1:0] tgt,
  output logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic             wr_out,
  output logic             fire
);

  localparam int unsigned PW_W = $clog2(PULSE_TICKS + 1);

  logic [PW_W-1:0] wcnt;

  assign fire = busy && !wr_out && (cnt == tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      wr_out <= 1'b0;
      wcnt   <= '0;
    end else begin
      if (accept) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(1);
      end else if (busy && !wr_out) begin
        cnt <= cnt + CNT_W'(1);
      end
      if (fire) begin
        wr_out <= 1'b1;
        wcnt   <= PW_W'(1);
      end else if (wr_out) begin
        if (wcnt == PW_W'(PULSE_TICKS)) begin
          wr_out <= 1'b0;
          busy   <= 1'b0;
        end else begin
          wcnt <= wcnt + PW_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/wpc_shifter.sv
module wpc_shifter
  import wpc_pkg::*;
#(
  parameter int unsigned BASE_TICKS   = 4,
  parameter int unsigned SAMPLE_TICKS = 2,
  parameter int unsigned PULSE_TICKS  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_in,
  input  logic       early_req,
  input  logic       late_req,
  input  logic [2:0] amt_sel,
  input  logic [1:0] rate_sel,
  output logic       wr_out,
  output logic       cfg_err,
  output logic       overrun
);

  // The base delay must exceed the sample point, so that the target is known before it is needed.
  localparam int unsigned EFF_BASE = (BASE_TICKS > SAMPLE_TICKS) ? BASE_TICKS : SAMPLE_TICKS + 1;
  localparam int unsigned MAX_D    = EFF_BASE + 2 * MAX_SHIFT + 2;
  localparam int unsigned CNT_W    = $clog2(MAX_D + 1);

  logic             accept;
  logic             busy;
  logic             fire;
  logic             sample_stb;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] tgt;

  wpc_edge_gate u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_in   (wr_in),
    .busy    (busy),
    .accept  (accept),
    .overrun (overrun)
  );

  wpc_delay_sel #(
    .BASE_TICKS   (EFF_BASE),
    .SAMPLE_TICKS (SAMPLE_TICKS),
    .CNT_W        (CNT_W)
  ) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .cnt        (cnt),
    .early_req  (early_req),
    .late_req   (late_req),
    .amt_sel    (amt_sel),
    .rate_sel   (rate_sel),
    .sample_stb (sample_stb),
    .tgt        (tgt),
    .cfg_err    (cfg_err)
  );

  wpc_pulse_gen #(
    .PULSE_TICKS (PULSE_TICKS),
    .CNT_W       (CNT_W)
  ) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .tgt    (tgt),
    .busy   (busy),
    .cnt    (cnt),
    .wr_out (wr_out),
    .fire   (fire)
  );

endmodule

// File: rtl/wpc_shifter_chk.sv
module wpc_shifter_chk #(
  parameter int unsigned PULSE_TICKS = 6,
  parameter int unsigned CNT_W       = 6
) (
  input logic clk,
  input logic rst_n,
  input logic wr_out,
  input logic cfg_err,
  input logic overrun,
  input logic busy,
  input logic sample_stb,
  input logic fire
);

  logic [CNT_W-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else        hi_cnt <= wr_out ? hi_cnt + CNT_W'(1) : '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!wr_out && !cfg_err && !overrun)); // R1
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(wr_out) |-> (hi_cnt == CNT_W'(PULSE_TICKS))); // R2
  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n) wr_out |-> !fire); // R2
  AST_FIRE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) fire |-> !sample_stb); // R6
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) cfg_err |=> !cfg_err); // R7
  AST_ERR_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) cfg_err |-> $past(sample_stb)); // R7
  AST_OVR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) overrun |-> $past(busy)); // R8

endmodule

bind wpc_shifter wpc_shifter_chk #(
  .PULSE_TICKS (PULSE_TICKS),
  .CNT_W       (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_out     (wr_out),
  .cfg_err    (cfg_err),
  .overrun    (overrun),
  .busy       (busy),
  .sample_stb (sample_stb),
  .fire       (fire)
);

// File: tb/wpc_shifter_tb.sv
`timescale 1ns/1ps
module wpc_shifter_tb;

  localparam int BASE = 4;
  localparam int SAMP = 2;
  localparam int PW   = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_in = 1'b0;
  logic       early_req = 1'b0;
  logic       late_req = 1'b0;
  logic [2:0] amt_sel = 3'd0;
  logic [1:0] rate_sel = 2'd0;
  wire        wr_out;
  wire        cfg_err;
  wire        overrun;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wpc_shifter #(
    .BASE_TICKS   (BASE),
    .SAMPLE_TICKS (SAMP),
    .PULSE_TICKS  (PW)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_in     (wr_in),
    .early_req (early_req),
    .late_req  (late_req),
    .amt_sel   (amt_sel),
    .rate_sel  (rate_sel),
    .wr_out    (wr_out),
    .cfg_err   (cfg_err),
    .overrun   (overrun)
  );

  function automatic bit legal_cfg(input int a, input int r);
    if (r == 3) return 1'b0;
    if (r == 2 && a >= 6) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int units_of(input int a, input int r);
    int slow [8] = '{0, 3, 4, 5, 6, 7, 9, 11};
    if (!legal_cfg(a, r)) return 0;
    if (r == 0) return slow[a];
    return a;
  endfunction

  function automatic int delay_of(input bit e, input bit l, input int a, input int r);
    int u = units_of(a, r);
    if (e && !l) return BASE;
    if (l && !e) return BASE + 2 * u;
    return BASE + u;
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic scramble();
    early_req = 1'($urandom());
    late_req  = 1'($urandom());
    amt_sel   = 3'($urandom());
    rate_sel  = 2'($urandom());
  endtask

  task automatic run_pulse(input bit e, input bit l, input int a, input int r,
                           input int wr_len, input int ovr_rel, input string tag);
    int  d = delay_of(e, l, a, r);
    bit  bad = !legal_cfg(a, r) || (e && l);
    int  wave_mis = 0;
    int  err_mis = 0;
    int  ovr_mis = 0;
    int  first_rise = -1;
    int  err_at = -1;
    int  extra = 0;
    @(negedge clk);
    for (int rel = 0; rel <= d + PW; rel++) begin
      wr_in = (rel < wr_len) || (ovr_rel > 0 && rel == ovr_rel);
      if (rel == SAMP) begin
        early_req = e; late_req = l; amt_sel = 3'(a); rate_sel = 2'(r);
      end else begin
        scramble();
      end
      @(negedge clk);
      if (wr_out !== ((rel >= d) && (rel < d + PW))) wave_mis++;
      if (wr_out === 1'b1 && first_rise < 0) first_rise = rel;
      if (cfg_err !== (bad && rel == SAMP)) err_mis++;
      if (cfg_err === 1'b1 && err_at < 0) err_at = rel;
      if (overrun !== (ovr_rel > 0 && rel == ovr_rel)) ovr_mis++;
    end
    wr_in = 1'b0;
    check(wave_mis == 0, tag, "delay ticks", first_rise, d);
    check(err_mis == 0, "R7", "cfg_err tick", err_at, bad ? SAMP : -1);
    check(ovr_mis == 0, "R8", "overrun mismatches", ovr_mis, 0);
    if (ovr_rel > 0) begin
      repeat (30) begin
        @(negedge clk);
        if (wr_out !== 1'b0 || overrun !== 1'b0) extra++;
      end
      check(extra == 0, "R8", "activity after dropped edge", extra, 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd424242));
    // R1: reset holds outputs low while the inputs toggle
    repeat (3) begin
      @(negedge clk);
      wr_in = ~wr_in;
      scramble();
    end
    check(wr_out === 1'b0 && cfg_err === 1'b0 && overrun === 1'b0, "R1", "outputs in reset",
          {wr_out, cfg_err, overrun}, 0);
    @(negedge clk);
    wr_in = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(wr_out === 1'b0, "R1", "wr_out after release", wr_out, 0);

    // R3: every amount code at the slowest rate, nominal timing
    for (int a = 0; a < 8; a++) run_pulse(1'b0, 1'b0, a, 0, 1, 0, "R3");
    // R4: the middle and fast rates
    for (int a = 0; a < 8; a++) run_pulse(1'b0, 1'b0, a, 1, 2, 0, "R4");
    for (int a = 0; a < 6; a++) run_pulse(1'b0, 1'b0, a, 2, 1, 0, "R4");
    // R5: early and late at the largest shifts
    run_pulse(1'b1, 1'b0, 7, 0, 1, 0, "R5");
    run_pulse(1'b0, 1'b1, 7, 0, 1, 0, "R5");
    run_pulse(1'b0, 1'b1, 7, 1, 3, 0, "R5");
    run_pulse(1'b1, 1'b0, 5, 2, 2, 0, "R5");
    // R7: illegal settings
    run_pulse(1'b1, 1'b1, 7, 0, 1, 0, "R7");
    run_pulse(1'b0, 1'b1, 6, 2, 1, 0, "R7");
    run_pulse(1'b0, 1'b1, 7, 2, 1, 0, "R7");
    run_pulse(1'b0, 1'b1, 4, 3, 1, 0, "R7");
    // R2: long high level gives a single pulse
    run_pulse(1'b0, 1'b0, 3, 0, 12, 0, "R2");
    // R6: requests scrambled on every tick except the sample tick
    run_pulse(1'b0, 1'b0, 2, 1, 1, 0, "R6");
    // R8: dropped edges at the first and the last busy tick
    run_pulse(1'b0, 1'b0, 0, 0, 1, 2, "R8");
    run_pulse(1'b0, 1'b0, 0, 0, 1, BASE + PW, "R8");

    for (int i = 0; i < 150; i++) begin
      int  r = ($urandom() % 8 == 0) ? 3 : int'($urandom() % 3);
      int  a = int'($urandom() % 8);
      bit  e = 1'($urandom());
      bit  l = 1'($urandom());
      int  wl = 1 + int'($urandom() % 3);
      int  d = delay_of(e, l, a, r);
      int  ov = 0;
      if ($urandom() % 5 == 0) ov = wl + 1 + int'($urandom() % (d + PW - wl));
      run_pulse(e, l, a, r, wl, ov, (r == 0) ? "R3" : "R4");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule